// File: doc/BRIEF.md
# Byte ALU with Condition Flags

This block computes one byte-wide arithmetic or logic operation per cycle and keeps the four condition flags that the operation produces: carry, zero, sign and overflow. The result is combinational from the operands and the operation code. The flags are held in a register that updates on the clock edge that ends the cycle in which `op_valid` is high. Each class of operation has its own rule for which flags it changes. A flag that an operation does not affect keeps its previous value.

The flag register also sits on a simple register bus at address 0xD5. Software can read it there, or load it as an ordinary register with no flag side effects. A write on the bus can land in the same cycle as a flag-producing operation, for example when the datapath writes an operation's result back to the flag register. In that case each flag the operation affects takes the computed value, and every other mapped flag takes the written data. Three single-cycle strobes set, clear or complement the carry flag without touching the other flags. The four flags are also driven out directly so that conditional-branch logic can evaluate them.

Top module: `byte_alu_status`

## Requirements
- R1: The flag register reads at bus address 0xD5 with carry in bit 7, zero in bit 6, sign in bit 5 and overflow in bit 4. Bits 3..0 always read 0. Any other address reads 0x00.
- R2: A bus write to 0xD5 with no operation in the same cycle loads bits 7..4 of the write data into the flags. Written bits 3..0 are dropped, and writes to any other address leave the flags unchanged.
- R3: Operation code 0 (add) returns a+b modulo 256. C is the carry out of bit 7, V is set when the signed sum leaves -128..+127, Z is set when the result is 0, and S equals result bit 7.
- R4: Operation code 1 (subtract) returns a-b modulo 256. C is set exactly when a < b as unsigned values (a borrow occurred), V is set on signed overflow, and Z and S follow the result.
- R5: Operation codes 2 (AND), 3 (OR) and 4 (XOR) update Z and S from the result, clear V and leave C unchanged.
- R6: Operation code 5 rotates a left (bit 7 moves to bit 0) and code 6 rotates a right (bit 0 moves to bit 7). C takes the bit that left the byte, Z and S follow the result, and V is unchanged.
- R7: Operation code 7 shifts a left and code 8 shifts a right, each filling with 0. C takes the last bit shifted out, Z and S follow the result, and V is unchanged.
- R8: Operation code 9 (bit test) returns a AND b and updates only Z. C, S and V are unchanged.
- R9: With no operation and no flag-register write in the cycle, `cf_set` sets C, `cf_clr` clears C and `cf_cpl` inverts C. When more than one strobe is high, set wins over clear and clear wins over complement. Z, S and V are untouched. The strobes are ignored in any cycle that has an operation or a flag-register write.
- R10: When an operation and a bus write to 0xD5 share a cycle, the flags the operation affects take the computed values. The remaining mapped flags take the written data.
- R11: After reset all four flags are 0.
- R12: Operation codes 10..15 return 0 and leave all flags unchanged.
- R13: The flag outputs `flag_c`, `flag_z`, `flag_s` and `flag_v` equal register bits 7, 6, 5 and 4 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation is applied to the flags at the next edge |
| op_code | input | 4 | Operation selector (see R3..R12) |
| op_a | input | 8 | First operand; the only operand for rotates and shifts |
| op_b | input | 8 | Second operand |
| result | output | 8 | Combinational operation result |
| bus_addr | input | 8 | Register-bus address |
| bus_wr | input | 1 | Register-bus write strobe |
| bus_wdata | input | 8 | Register-bus write data |
| bus_rdata | output | 8 | Register-bus read data (combinational) |
| cf_set | input | 1 | Set carry |
| cf_clr | input | 1 | Clear carry |
| cf_cpl | input | 1 | Complement carry |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The only state is the four flag bits, and a wrong flag shows at the flag outputs and on a read of 0xD5 in the cycle after the edge that stored it. It can be caught no later than the next read. A fault in the masking that decides which flags an operation keeps stays hidden unless the flags held beforehand differ from the computed values. For that reason, each operation class is run after the flags have been preloaded with a contrasting pattern. Priority faults between an operation, a bus write and the carry strobes show only when those inputs collide in one cycle. These collisions are driven on purpose, and the stored flags are read back on the following cycle.

// File: rtl/bas_pkg.sv
package bas_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_ROL  = 4'd5,
        OP_ROR  = 4'd6,
        OP_SHL  = 4'd7,
        OP_SHR  = 4'd8,
        OP_TEST = 4'd9
    } alu_op_e;

    // bit order matches the register layout, high to low: C Z S V
    typedef struct packed {
        logic c;
        logic z;
        logic s;
        logic v;
    } flag_t;

    localparam int FLAG_W = 4;

endpackage

// File: rtl/bas_alu_core.sv
module bas_alu_core
    import bas_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [3:0]        op_code,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res,
    output flag_t             upd_mask,
    output flag_t             upd_val
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] sum_w;
    logic [DATA_W:0] dif_w;

    always_comb begin
        sum_w    = {1'b0, a} + {1'b0, b};
        dif_w    = {1'b0, a} - {1'b0, b};
        res      = '0;
        upd_mask = '0;
        upd_val  = '0;
        case (alu_op_e'(op_code))
            OP_ADD: begin
                res       = sum_w[MSB:0];
                upd_val.c = sum_w[DATA_W];
                upd_val.v = (a[MSB] == b[MSB]) && (res[MSB] != a[MSB]);
                upd_mask  = '{c: 1'b1, z: 1'b1, s: 1'b1, v: 1'b1};
            end
            OP_SUB: begin
                res       = dif_w[MSB:0];
                upd_val.c = dif_w[DATA_W];
                upd_val.v = (a[MSB] != b[MSB]) && (res[MSB] != a[MSB]);
                upd_mask  = '{c: 1'b1, z: 1'b1, s: 1'b1, v: 1'b1};
            end
            OP_AND, OP_OR, OP_XOR: begin
                if (alu_op_e'(op_code) == OP_AND)     res = a & b;
                else if (alu_op_e'(op_code) == OP_OR) res = a | b;
                else                                  res = a ^ b;
                upd_val.v = 1'b0;
                upd_mask  = '{c: 1'b0, z: 1'b1, s: 1'b1, v: 1'b1};
            end
            OP_ROL: begin
                res       = {a[MSB-1:0], a[MSB]};
                upd_val.c = a[MSB];
                upd_mask  = '{c: 1'b1, z: 1'b1, s: 1'b1, v: 1'b0};
            end
            OP_ROR: begin
                res       = {a[0], a[MSB:1]};
                upd_val.c = a[0];
                upd_mask  = '{c: 1'b1, z: 1'b1, s: 1'b1, v: 1'b0};
            end
            OP_SHL: begin
                res       = {a[MSB-1:0], 1'b0};
                upd_val.c = a[MSB];
                upd_mask  = '{c: 1'b1, z: 1'b1, s: 1'b1, v: 1'b0};
            end
            OP_SHR: begin
                res       = {1'b0, a[MSB:1]};
                upd_val.c = a[0];
                upd_mask  = '{c: 1'b1, z: 1'b1, s: 1'b1, v: 1'b0};
            end
            OP_TEST: begin
                res       = a & b;
                upd_mask  = '{c: 1'b0, z: 1'b1, s: 1'b0, v: 1'b0};
            end
            default: begin
                res       = '0;
                upd_mask  = '0;
            end
        endcase
        upd_val.z = (res == '0);
        upd_val.s = res[MSB];
    end

endmodule

// File: rtl/bas_flag_reg.sv
module bas_flag_reg
    import bas_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  op_fire,
    input  flag_t upd_mask,
    input  flag_t upd_val,
    input  logic  wr_hit,
    input  flag_t wr_flags,
    input  logic  cf_set,
    input  logic  cf_clr,
    input  logic  cf_cpl,
    output flag_t flags
);

    typedef struct packed {
        flag_t fl;
    } state_t;

    state_t st_d;
    state_t st_q;

    always_comb begin
        st_d = st_q;
        if (wr_hit) begin
            st_d.fl = wr_flags;
        end
        if (op_fire) begin
            // computed flags win over the data write, bit by bit
            st_d.fl = (upd_mask & upd_val) | (~upd_mask & st_d.fl);
        end else if (!wr_hit) begin
            if (cf_set)      st_d.fl.c = 1'b1;
            else if (cf_clr) st_d.fl.c = 1'b0;
            else if (cf_cpl) st_d.fl.c = ~st_q.fl.c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.fl;

endmodule

// File: rtl/byte_alu_status.sv
module byte_alu_status
    import bas_pkg::*;
#(
    parameter int                DATA_W    = 8,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'hD5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic [DATA_W-1:0] result,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cf_set,
    input  logic              cf_clr,
    input  logic              cf_cpl,
    output logic              flag_c,
    output logic              flag_z,
    output logic              flag_s,
    output logic              flag_v
);

    localparam int PAD_W = DATA_W - FLAG_W;

    flag_t upd_mask;
    flag_t upd_val;
    flag_t flags;
    flag_t wr_flags;
    logic  addr_hit;
    logic  wr_hit;

    assign addr_hit = (bus_addr == FLAG_ADDR);
    assign wr_hit   = bus_wr && addr_hit;
    assign wr_flags = flag_t'(bus_wdata[DATA_W-1 -: FLAG_W]);

    bas_alu_core #(.DATA_W(DATA_W)) u_core (
        .op_code  (op_code),
        .a        (op_a),
        .b        (op_b),
        .res      (result),
        .upd_mask (upd_mask),
        .upd_val  (upd_val)
    );

    bas_flag_reg u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_fire  (op_valid),
        .upd_mask (upd_mask),
        .upd_val  (upd_val),
        .wr_hit   (wr_hit),
        .wr_flags (wr_flags),
        .cf_set   (cf_set),
        .cf_clr   (cf_clr),
        .cf_cpl   (cf_cpl),
        .flags    (flags)
    );

    assign bus_rdata = addr_hit ? {flags, {PAD_W{1'b0}}} : '0;
    assign flag_c    = flags.c;
    assign flag_z    = flags.z;
    assign flag_s    = flags.s;
    assign flag_v    = flags.v;

endmodule

// File: rtl/bas_flags_chk.sv
module bas_flags_chk #(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'hD5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [3:0]        op_code,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              cf_set,
    input logic              cf_clr,
    input logic              cf_cpl,
    input logic              flag_c,
    input logic              flag_z,
    input logic              flag_s,
    input logic              flag_v
);

    logic [3:0] fl;
    logic       wr_hit;
    logic       is_logic;
    logic       any_cf;

    assign fl       = {flag_c, flag_z, flag_s, flag_v};
    assign wr_hit   = bus_wr && (bus_addr == FLAG_ADDR);
    assign is_logic = (op_code == 4'd2) || (op_code == 4'd3) || (op_code == 4'd4);
    assign any_cf   = cf_set || cf_clr || cf_cpl;

    // R1
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[3:0] == 4'h0);

    // R13
    flag_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == FLAG_ADDR) |-> (bus_rdata[7:4] == fl));

    // R2
    bus_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !op_valid) |=> (fl == $past(bus_wdata[7:4])));

    // R5
    logic_clr_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_logic) |=> !flag_v);

    // R9
    carry_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cf_set && !op_valid && !wr_hit) |=> flag_c);

    // R9
    carry_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_cf && !op_valid && !wr_hit) |=> $stable({flag_z, flag_s, flag_v}));

    // R8
    test_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd9 && !wr_hit) |=> $stable({flag_c, flag_s, flag_v}));

    // R12
    unused_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code > 4'd9 && !wr_hit) |=> $stable(fl));

endmodule

bind byte_alu_status bas_flags_chk #(.ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR)) u_chk (.*);

// File: tb/byte_alu_status_tb.sv
module byte_alu_status_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = '0;
    logic [7:0] op_a = '0;
    logic [7:0] op_b = '0;
    logic [7:0] result;
    logic [7:0] bus_addr = 8'hD5;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cf_set = 1'b0;
    logic       cf_clr = 1'b0;
    logic       cf_cpl = 1'b0;
    logic       flag_c, flag_z, flag_s, flag_v;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    byte_alu_status u_dut (.*);

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // read flags through the bus and through the flag pins
    task automatic rd_flags(input string tag, input logic [7:0] exp);
        bus_addr = 8'hD5;
        #1;
        chk(tag, bus_rdata, exp);
        chk({tag, " pins R13"}, {flag_c, flag_z, flag_s, flag_v, 4'h0}, exp);
    endtask

    task automatic bus_write(input logic [7:0] addr, input logic [7:0] data);
        bus_addr  = addr;
        bus_wdata = data;
        bus_wr    = 1'b1;
        step();
        bus_wr    = 1'b0;
        bus_addr  = 8'hD5;
    endtask

    task automatic run_op(input string tag, input logic [3:0] op, input logic [7:0] a,
                          input logic [7:0] b, input logic [7:0] exp_res,
                          input logic [7:0] exp_fl);
        op_code  = op;
        op_a     = a;
        op_b     = b;
        op_valid = 1'b1;
        #1;
        chk({tag, " result"}, result, exp_res);
        step();
        op_valid = 1'b0;
        rd_flags({tag, " flags"}, exp_fl);
    endtask

    task automatic t_reset();
        rd_flags("R11 reset flags", 8'h00);
    endtask

    task automatic t_bus();
        bus_write(8'hD5, 8'hFF);
        rd_flags("R2 load FF, low bits dropped (R1)", 8'hF0);
        bus_write(8'h10, 8'h5A);
        rd_flags("R2 other address ignored", 8'hF0);
        bus_addr = 8'h10;
        #1;
        chk("R1 other address reads 0", bus_rdata, 8'h00);
        bus_write(8'hD5, 8'h9F);
        rd_flags("R2 load 9F", 8'h90);
    endtask

    task automatic t_add();
        bus_write(8'hD5, 8'h00);
        run_op("R3 7F+01", 4'd0, 8'h7F, 8'h01, 8'h80, 8'h30);
        run_op("R3 FF+01", 4'd0, 8'hFF, 8'h01, 8'h00, 8'hC0);
        run_op("R3 80+80", 4'd0, 8'h80, 8'h80, 8'h00, 8'hD0);
        run_op("R3 12+34", 4'd0, 8'h12, 8'h34, 8'h46, 8'h00);
    endtask

    task automatic t_sub();
        run_op("R4 10-20", 4'd1, 8'h10, 8'h20, 8'hF0, 8'hA0);
        run_op("R4 80-01", 4'd1, 8'h80, 8'h01, 8'h7F, 8'h10);
        run_op("R4 33-33", 4'd1, 8'h33, 8'h33, 8'h00, 8'h40);
        run_op("R4 7F-FF", 4'd1, 8'h7F, 8'hFF, 8'h80, 8'hB0);
    endtask

    task automatic t_logic();
        bus_write(8'hD5, 8'h90);
        run_op("R5 AND", 4'd2, 8'hF0, 8'h0F, 8'h00, 8'hC0);
        bus_write(8'hD5, 8'h10);
        run_op("R5 OR",  4'd3, 8'h80, 8'h01, 8'h81, 8'h20);
        bus_write(8'hD5, 8'h90);
        run_op("R5 XOR", 4'd4, 8'hFF, 8'hFF, 8'h00, 8'hC0);
    endtask

    task automatic t_rotate();
        bus_write(8'hD5, 8'h10);
        run_op("R6 rol 81", 4'd5, 8'h81, 8'h00, 8'h03, 8'h90);
        run_op("R6 ror 01", 4'd6, 8'h01, 8'h00, 8'h80, 8'hB0);
        run_op("R6 rol 00", 4'd5, 8'h00, 8'h00, 8'h00, 8'h50);
        run_op("R6 ror 02", 4'd6, 8'h02, 8'h00, 8'h01, 8'h10);
    endtask

    task automatic t_shift();
        bus_write(8'hD5, 8'h00);
        run_op("R7 shl 80", 4'd7, 8'h80, 8'h00, 8'h00, 8'hC0);
        run_op("R7 shr 01", 4'd8, 8'h01, 8'h00, 8'h00, 8'hC0);
        run_op("R7 shr 82", 4'd8, 8'h82, 8'h00, 8'h41, 8'h00);
        bus_write(8'hD5, 8'h10);
        run_op("R7 shl 40", 4'd7, 8'h40, 8'h00, 8'h80, 8'h30);
    endtask

    task automatic t_test();
        bus_write(8'hD5, 8'hB0);
        run_op("R8 test zero",    4'd9, 8'h0F, 8'hF0, 8'h00, 8'hF0);
        run_op("R8 test nonzero", 4'd9, 8'h81, 8'h81, 8'h81, 8'hB0);
    endtask

    task automatic t_carry();
        bus_write(8'hD5, 8'h70);
        cf_set = 1'b1; step(); cf_set = 1'b0;
        rd_flags("R9 set", 8'hF0);
        cf_clr = 1'b1; step(); cf_clr = 1'b0;
        rd_flags("R9 clear", 8'h70);
        cf_cpl = 1'b1; step(); cf_cpl = 1'b0;
        rd_flags("R9 complement 0->1", 8'hF0);
        cf_cpl = 1'b1; step(); cf_cpl = 1'b0;
        rd_flags("R9 complement 1->0", 8'h70);
        cf_set = 1'b1; cf_clr = 1'b1; step(); cf_set = 1'b0; cf_clr = 1'b0;
        rd_flags("R9 set beats clear", 8'hF0);
        cf_clr = 1'b1; cf_cpl = 1'b1; step(); cf_clr = 1'b0; cf_cpl = 1'b0;
        rd_flags("R9 clear beats complement", 8'h70);
        // strobe ignored during a flag-register write
        cf_set = 1'b1;
        bus_write(8'hD5, 8'h00);
        cf_set = 1'b0;
        rd_flags("R9 set ignored on write", 8'h00);
        // strobe ignored during an operation (AND keeps C=0)
        cf_set = 1'b1;
        run_op("R9 set ignored on op", 4'd2, 8'h01, 8'h01, 8'h01, 8'h00);
        cf_set = 1'b0;
    endtask

    task automatic t_collide();
        bus_write(8'hD5, 8'h00);
        bus_addr  = 8'hD5;
        bus_wdata = 8'h30;
        bus_wr    = 1'b1;
        run_op("R10 add over write", 4'd0, 8'hFF, 8'h01, 8'h00, 8'hC0);
        bus_wdata = 8'hA0;
        bus_wr    = 1'b1;
        run_op("R10 test merges write", 4'd9, 8'h00, 8'h00, 8'h00, 8'hE0);
        bus_wdata = 8'h00;
        bus_wr    = 1'b1;
        run_op("R10 test nonzero merges write", 4'd9, 8'h01, 8'h01, 8'h01, 8'h00);
        bus_wr    = 1'b0;
        bus_wdata = 8'hF0;
        bus_wr    = 1'b1;
        run_op("R10 logic keeps written C", 4'd3, 8'h00, 8'h00, 8'h00, 8'hC0);
        bus_wr    = 1'b0;
    endtask

    task automatic t_unused();
        bus_write(8'hD5, 8'hF0);
        run_op("R12 code 12", 4'd12, 8'h55, 8'hAA, 8'h00, 8'hF0);
        run_op("R12 code 15", 4'd15, 8'hFF, 8'h01, 8'h00, 8'hF0);
    endtask

    initial begin
        #(200000 * 10);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bus();
        t_add();
        t_sub();
        t_logic();
        t_rotate();
        t_shift();
        t_test();
        t_carry();
        t_collide();
        t_unused();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule